// File: doc/BRIEF.md
# I2C Target Address-Match Controller

This block is the receive-side front end of an I2C target. It oversamples the two bus lines on the system clock, recognises START, repeated START and STOP events, and keeps a bus-busy flag. After each START it shifts in the address byte and compares it with a programmable 7-bit own address. It can also accept the general-call address when software allows it. On a match it acknowledges, pulses an interrupt request and latches the direction bit.

In write direction, each data byte is handed to local logic through a valid/ready stream. In read direction, bytes are fetched from local logic through a second valid/ready stream. A source may hold `tx_valid` or a sink may hold `rx_ready` low for as long as it likes. The block then holds SCL low after the acknowledge clock until the stream can move. The pending received byte and its `rx_valid` stay stable until the handshake.

The bus pins are modelled as open-drain: `sda_pull` and `scl_hold` mean "pull the line low".

Top module: `i2c_target_ctl`

## Requirements
- R1: `bus_busy` is 0 after reset, goes to 1 when a START is seen and returns to 0 only on a STOP; a repeated START leaves it at 1.
- R2: A START is a falling SDA while SCL is high, and a STOP is a rising SDA while SCL is high. A START while addressed (repeated START) drops `addressed` and restarts address reception without a STOP.
- R3: Address bits arrive MSB first. The target matches when byte bits [7:1] equal `cfg_addr[7:1]`, for either value of the R/W bit (byte bit 0), and acknowledges by pulling SDA low for the 9th clock. A byte that does not match is not acknowledged, and bus activity is then ignored until the next START.
- R4: The address byte 8'h00 is also matched (general call), but only while `cfg_addr[0]` is 1. The byte 8'h01 is never a general call.
- R5: Each address match gives exactly one single-cycle `irq_match` pulse, and `addressed` is high from the match until the next START or STOP. `rd_mode` holds the matched R/W bit.
- R6: In write direction, each received byte is acknowledged and presented on `rx_data` with `rx_valid`. Both are held stable until a cycle with `rx_ready` high.
- R7: If a received byte is still unaccepted when the acknowledge clock falls, SCL is held low. It is released on the same clock edge that accepts the byte.
- R8: In read direction, a byte is taken on a `tx_valid`/`tx_ready` cycle and sent MSB first. SDA changes only while SCL is low.
- R9: If no byte is offered when one is due (after the read address or after a master ACK), SCL is held low until `tx_valid` rises. The byte that is then taken is sent.
- R10: A master not-acknowledge ends transmission. SDA is released, and no byte is taken until the next START.
- R11: After a STOP the block is not addressed, and both `sda_pull` and `scl_hold` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_hold | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low |
| cfg_addr | input | 8 | [7:1] own address, [0] general-call enable |
| bus_busy | output | 1 | Bus between START and STOP |
| irq_match | output | 1 | One-cycle pulse on an address match |
| addressed | output | 1 | Target selected in the current transfer |
| rd_mode | output | 1 | Matched direction, 1 = master reads |
| rx_valid | output | 1 | Received byte pending |
| rx_ready | input | 1 | Local sink accepts the pending byte |
| rx_data | output | 8 | Received byte |
| tx_valid | input | 1 | Local source offers a byte |
| tx_ready | output | 1 | Block takes the offered byte this cycle |
| tx_data | input | 8 | Byte to transmit |

## Verification
Two functions can fall in the same cycle. The receive sink accepting the held byte and the release of a stretched SCL both happen on one clock edge. The bench provokes this by keeping `rx_ready` low through the acknowledge clock, so that SCL is stretched, and then raising it for a single cycle. At the following sample point it expects `rx_valid` and `scl_hold` to be 0 together, and the master's next byte must then go through.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_RWAIT,
    ST_TX,
    ST_TACK,
    ST_TWAIT,
    ST_SKIP
  } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser with one extra history stage per line.
module i2c_tgt_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] now,
  output logic [LINES-1:0] prev
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], raw[g]};
    end
    assign now[g]  = chain[STAGES-1];
    assign prev[g] = chain[STAGES];
  end
endmodule

// File: rtl/i2c_tgt_cond.sv
`timescale 1ns/1ps
// Bus event decoder: SCL edges, START/STOP, busy flag.
module i2c_tgt_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_now,
  input  logic scl_prev,
  input  logic sda_now,
  input  logic sda_prev,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p,
  output logic bus_busy
);
  logic scl_steady_hi;

  assign scl_steady_hi = scl_now & scl_prev;
  assign scl_rise      = scl_now & ~scl_prev;
  assign scl_fall      = ~scl_now & scl_prev;
  assign start_p       = scl_steady_hi & sda_prev & ~sda_now;
  assign stop_p        = scl_steady_hi & ~sda_prev & sda_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bus_busy <= 1'b0;
    else if (start_p) bus_busy <= 1'b1;
    else if (stop_p)  bus_busy <= 1'b0;
  end
endmodule

// File: rtl/i2c_tgt_addr_cmp.sv
`timescale 1ns/1ps
// Address comparator: own address and optional general call.
module i2c_tgt_addr_cmp #(
  parameter int AW = 7
) (
  input  logic [AW:0] addr_byte,
  input  logic [AW:0] cfg_addr,
  output logic        hit
);
  logic own_hit;
  logic gc_hit;

  assign own_hit = (addr_byte[AW:1] == cfg_addr[AW:1]);
  assign gc_hit  = cfg_addr[0] & (addr_byte == '0);
  assign hit     = own_hit | gc_hit;
endmodule

// File: rtl/i2c_tgt_engine.sv
`timescale 1ns/1ps
// Byte sequencer: address phase, acknowledge, receive/transmit, stretching.
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_now,
  input  logic          addr_hit,
  output logic [DW-1:0] shreg,
  output logic          sda_pull,
  output logic          scl_hold,
  output logic          irq_match,
  output logic          addressed,
  output logic          rd_mode,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW);
  localparam logic [CW-1:0] LAST_TX  = CW'(DW - 1);

  tgt_state_t    state;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] txsr;
  logic          nack_q;
  logic          tx_load;
  logic          rx_drain;

  assign tx_ready = (state == ST_TWAIT) |
                    (scl_fall & (((state == ST_AACK) & rd_mode) |
                                 ((state == ST_TACK) & ~nack_q)));
  assign tx_load  = tx_ready & tx_valid & ~start_p & ~stop_p;
  assign rx_drain = rx_valid & rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txsr      <= '0;
      nack_q    <= 1'b0;
      sda_pull  <= 1'b0;
      scl_hold  <= 1'b0;
      irq_match <= 1'b0;
      addressed <= 1'b0;
      rd_mode   <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
    end else begin
      irq_match <= 1'b0;
      if (rx_drain) rx_valid <= 1'b0;

      if (start_p) begin
        state     <= ST_ADDR;
        bitcnt    <= '0;
        sda_pull  <= 1'b0;
        scl_hold  <= 1'b0;
        addressed <= 1'b0;
      end else if (stop_p) begin
        state     <= ST_IDLE;
        sda_pull  <= 1'b0;
        scl_hold  <= 1'b0;
        addressed <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg  <= {shreg[DW-2:0], sda_now};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              if (addr_hit) begin
                sda_pull  <= 1'b1;
                irq_match <= 1'b1;
                addressed <= 1'b1;
                rd_mode   <= shreg[0];
                state     <= ST_AACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bitcnt   <= '0;
              if (rd_mode) begin
                if (!tx_valid) begin
                  scl_hold <= 1'b1;
                  state    <= ST_TWAIT;
                end
              end else if (rx_valid && !rx_ready) begin
                scl_hold <= 1'b1;
                state    <= ST_RWAIT;
              end else begin
                state <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[DW-2:0], sda_now};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              rx_data  <= shreg;
              rx_valid <= 1'b1;
              sda_pull <= 1'b1;
              state    <= ST_RACK;
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bitcnt   <= '0;
              if (rx_valid && !rx_ready) begin
                scl_hold <= 1'b1;
                state    <= ST_RWAIT;
              end else begin
                state <= ST_RX;
              end
            end
          end
          ST_RWAIT: begin
            if (!rx_valid || rx_ready) begin
              scl_hold <= 1'b0;
              state    <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_hold) scl_hold <= 1'b0;
            if (scl_fall) begin
              if (bitcnt == LAST_TX) begin
                sda_pull <= 1'b0;
                state    <= ST_TACK;
              end else begin
                txsr     <= {txsr[DW-2:0], 1'b0};
                sda_pull <= ~txsr[DW-2];
                bitcnt   <= bitcnt + 1'b1;
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              nack_q <= sda_now;
            end else if (scl_fall) begin
              if (nack_q) begin
                state <= ST_SKIP;
              end else if (!tx_valid) begin
                scl_hold <= 1'b1;
                state    <= ST_TWAIT;
              end
            end
          end
          ST_TWAIT: ;
          default: ;
        endcase

        if (tx_load) begin
          txsr     <= tx_data;
          sda_pull <= ~tx_data[DW-1];
          bitcnt   <= '0;
          state    <= ST_TX;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_target_ctl.sv
`timescale 1ns/1ps
module i2c_target_ctl
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_hold,
  output logic              sda_pull,
  input  logic [ADDR_W:0]   cfg_addr,
  output logic              bus_busy,
  output logic              irq_match,
  output logic              addressed,
  output logic              rd_mode,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data
);
  logic [1:0]        line_now;
  logic [1:0]        line_prev;
  logic              scl_now;
  logic              scl_prev;
  logic              sda_now;
  logic              sda_prev;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_p;
  logic              stop_p;
  logic              addr_hit;
  logic [BYTE_W-1:0] shreg;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({sda_in, scl_in}),
    .now  (line_now),
    .prev (line_prev)
  );

  assign scl_now  = line_now[0];
  assign sda_now  = line_now[1];
  assign scl_prev = line_prev[0];
  assign sda_prev = line_prev[1];

  i2c_tgt_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_now (scl_now),
    .scl_prev(scl_prev),
    .sda_now (sda_now),
    .sda_prev(sda_prev),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_p (start_p),
    .stop_p  (stop_p),
    .bus_busy(bus_busy)
  );

  i2c_tgt_addr_cmp #(.AW(ADDR_W)) u_cmp (
    .addr_byte(shreg),
    .cfg_addr (cfg_addr),
    .hit      (addr_hit)
  );

  i2c_tgt_engine #(.DW(BYTE_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_now  (sda_now),
    .addr_hit (addr_hit),
    .shreg    (shreg),
    .sda_pull (sda_pull),
    .scl_hold (scl_hold),
    .irq_match(irq_match),
    .addressed(addressed),
    .rd_mode  (rd_mode),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data)
  );
endmodule

// File: rtl/i2c_target_ctl_chk.sv
`timescale 1ns/1ps
module i2c_target_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_p,
  input logic       stop_p,
  input logic       scl_now,
  input logic       scl_prev,
  input logic       bus_busy,
  input logic       sda_pull,
  input logic       scl_hold,
  input logic       irq_match,
  input logic       addressed,
  input logic       rd_mode,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       tx_valid,
  input logic       tx_ready
);
  assert_busy_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> bus_busy);
  assert_busy_clr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !bus_busy);
  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !addressed);
  assert_irq_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_match |-> addressed);
  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_match |=> !irq_match);
  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  assert_rx_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && scl_hold && !rd_mode) |=> !scl_hold);
  assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> !scl_now);
  assert_sda_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_now && scl_prev && !start_p && !stop_p) |=> $stable(sda_pull));
  assert_tx_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> ##1 !scl_hold);
  assert_stop_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> (!addressed && !sda_pull && !scl_hold));
endmodule

bind i2c_target_ctl i2c_target_ctl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_p  (start_p),
  .stop_p   (stop_p),
  .scl_now  (scl_now),
  .scl_prev (scl_prev),
  .bus_busy (bus_busy),
  .sda_pull (sda_pull),
  .scl_hold (scl_hold),
  .irq_match(irq_match),
  .addressed(addressed),
  .rd_mode  (rd_mode),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rx_data  (rx_data),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready)
);

// File: tb/i2c_target_ctl_tb.sv
`timescale 1ns/1ps
module i2c_target_ctl_tb;
  localparam int CLK_P = 10;
  localparam int Q     = 16;

  // {cfg_addr, address byte, data byte, expect match}
  localparam logic [24:0] VECS [6] = '{
    {8'hA4, 8'hA4, 8'h3C, 1'b1},
    {8'hA4, 8'hA6, 8'h55, 1'b0},
    {8'hA4, 8'h00, 8'h11, 1'b0},
    {8'hA5, 8'h00, 8'h81, 1'b1},
    {8'h7E, 8'h7E, 8'hFF, 1'b1},
    {8'h7F, 8'h01, 8'h22, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic scl_hold, sda_pull;
  wire  scl_line = scl_m & ~scl_hold;
  wire  sda_line = sda_m & ~sda_pull;

  logic [7:0] cfg = 8'hA4;
  logic       rx_ready = 1'b1;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_bytes [4] = '{8'h5A, 8'hC3, 8'h0F, 8'h99};
  int         tx_idx = 0;
  wire  [7:0] tx_data = tx_bytes[tx_idx[1:0]];
  logic       bus_busy, irq_match, addressed, rd_mode, rx_valid, tx_ready;
  logic [7:0] rx_data;

  i2c_target_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_hold(scl_hold), .sda_pull(sda_pull), .cfg_addr(cfg),
    .bus_busy(bus_busy), .irq_match(irq_match), .addressed(addressed),
    .rd_mode(rd_mode), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data)
  );

  int         irq_cnt = 0;
  int         rx_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  always @(posedge clk) begin
    if (irq_match) irq_cnt <= irq_cnt + 1;
    if (rx_valid && rx_ready) begin
      rx_cnt  <= rx_cnt + 1;
      rx_last <= rx_data;
    end
    if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
  end

  int errs = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; wait_scl(); tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; wait_scl(); tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic m_bit(input bit b, output bit s);
    sda_m = b; tick(Q);
    scl_m = 1'b1; wait_scl(); tick(Q);
    s = sda_line;
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) m_bit(d[i], s);
    m_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic m_rbyte(input bit ack, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, s);
      d[i] = s;
    end
    m_bit(!ack, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    bit         ack;
    logic [7:0] d;
    int         i0, r0, t0;

    tick(5);
    rst_n = 1'b1;
    tick(4);
    // Reset state
    chk(!bus_busy, "R1 reset busy", bus_busy, 0);
    chk(!scl_hold && !sda_pull, "R11 reset lines", {scl_hold, sda_pull}, 0);
    chk(!addressed, "R5 reset addressed", addressed, 0);
    chk(!rx_valid, "R6 reset rx_valid", rx_valid, 0);

    // Vector walk: address match / general call / ignore
    for (int v = 0; v < 6; v++) begin
      logic [7:0] ab, db;
      bit         exp_m;
      cfg   = VECS[v][24:17];
      ab    = VECS[v][16:9];
      db    = VECS[v][8:1];
      exp_m = VECS[v][0];
      i0 = irq_cnt;
      r0 = rx_cnt;
      m_start();
      chk(bus_busy, "R1 busy in transfer", bus_busy, 1);
      m_wbyte(ab, ack);
      chk(ack == exp_m, "R3/R4 address ack", ack, exp_m);
      m_wbyte(db, ack);
      chk(ack == exp_m, "R6 data ack (R3 ignore)", ack, exp_m);
      m_stop();
      tick(4);
      chk(irq_cnt - i0 == int'(exp_m), "R5 irq count", irq_cnt - i0, exp_m);
      chk(rx_cnt - r0 == int'(exp_m), "R6 rx count", rx_cnt - r0, exp_m);
      if (exp_m) chk(rx_last == db, "R6 rx data", rx_last, db);
      chk(!bus_busy, "R1 free after STOP", bus_busy, 0);
      chk(!addressed, "R11 not addressed", addressed, 0);
    end

    // Repeated START, read with ACK then NACK
    cfg = 8'hA4;
    i0 = irq_cnt;
    tx_valid = 1'b1;
    m_start();
    m_wbyte(8'hA4, ack);
    chk(ack && addressed && !rd_mode, "R5 write select", {ack, addressed, rd_mode}, 3'b110);
    m_wbyte(8'h10, ack);
    m_start();
    chk(!addressed, "R2 restart clears select", addressed, 0);
    chk(bus_busy, "R1 busy kept over restart", bus_busy, 1);
    m_wbyte(8'hA5, ack);
    chk(ack, "R3 read address ack", ack, 1);
    chk(rd_mode, "R5 rd_mode", rd_mode, 1);
    m_rbyte(1'b1, d);
    chk(d == 8'h5A, "R8 first byte", d, 8'h5A);
    m_rbyte(1'b0, d);
    chk(d == 8'hC3, "R8 second byte", d, 8'hC3);
    tick(Q);
    chk(!sda_pull, "R10 sda released", sda_pull, 0);
    chk(tx_idx == 2, "R10 bytes taken", tx_idx, 2);
    m_rbyte(1'b0, d);
    chk(d == 8'hFF && tx_idx == 2, "R10 no transmit after nack", d, 8'hFF);
    m_stop();
    tick(4);
    chk(irq_cnt - i0 == 2, "R5 one pulse per match", irq_cnt - i0, 2);
    chk(!addressed && !scl_hold && !sda_pull, "R11 idle after stop",
        {addressed, scl_hold, sda_pull}, 0);
    tx_valid = 1'b0;

    // Transmit stretch
    m_start();
    m_wbyte(8'hA5, ack);
    chk(scl_hold, "R9 hold when no byte", scl_hold, 1);
    fork
      m_rbyte(1'b0, d);
      begin
        tick(3 * Q);
        chk(scl_hold, "R9 still holding", scl_hold, 1);
        tx_valid = 1'b1;
      end
    join
    chk(d == 8'h0F, "R9 byte after stretch", d, 8'h0F);
    tx_valid = 1'b0;
    m_stop();

    // Receive stretch and same-edge release
    rx_ready = 1'b0;
    t0 = rx_cnt;
    m_start();
    m_wbyte(8'hA4, ack);
    m_wbyte(8'h66, ack);
    chk(ack, "R6 ack while sink busy", ack, 1);
    tick(2);
    chk(scl_hold, "R7 stretch on full", scl_hold, 1);
    chk(rx_valid && rx_data == 8'h66, "R6 byte held", rx_data, 8'h66);
    fork
      m_wbyte(8'h77, ack);
      begin
        tick(2 * Q);
        chk(scl_hold && rx_valid, "R7 holding until accept", scl_hold, 1);
        rx_ready = 1'b1;
        @(negedge clk);
        chk(!rx_valid && !scl_hold, "R7 release same edge", {rx_valid, scl_hold}, 0);
        rx_ready = 1'b0;
      end
    join
    chk(rx_cnt - t0 == 1, "R6 one byte accepted", rx_cnt - t0, 1);
    rx_ready = 1'b1;
    tick(4);
    chk(rx_last == 8'h77, "R6 second byte", rx_last, 8'h77);
    m_stop();
    tick(4);
    chk(!bus_busy, "R1 free at end", bus_busy, 0);

    summary();
  end
endmodule